// File: doc/BRIEF.md
# Tagged Receive Byte Queue

This block is the receive-side queue between an internal line controller and a host. It stores up to 16 received bytes. Each byte carries three error tags: parity, framing and break. The controller reports a byte in two steps. It first writes the tags into a staging register. It then writes the byte, and the queue stores the byte together with the staged tags in one 11-bit entry. The host pops bytes in arrival order. With each pop it sees the tags of that byte in its line-status word. A summary status bit stays high while any stored entry still carries a non-zero tag.

Occupancy is tracked by a three-state machine with the states Q_EMPTY, Q_PART and Q_FULL. The transitions are:

- GO_FILL: Q_EMPTY to Q_PART on a push.
- GO_FULL: Q_PART to Q_FULL on a push at one below depth.
- GO_DRAIN: Q_FULL to Q_PART on a pop.
- GO_EMPTY: Q_PART to Q_EMPTY on a pop of the last entry.
- GO_FLUSH: any state to Q_EMPTY on a flush.

A simultaneous push and pop in Q_PART holds the state. A host configuration write carries an enable bit (bit 0), a flush bit (bit 1) and a two-bit trigger select (bits 7..6). A trigger flag reports when the stored count reaches the selected level.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: A data write stores the byte with the staged tags as {break, framing, parity} in entry bits 10..8. After any data write the staged tags return to zero, so a following byte written without a tag write carries tags 000.
- R2: A host pop returns the oldest byte on `rd_data` after the clock edge. The same edge loads that byte's tags into `lsr` bit 2 (parity), bit 3 (framing) and bit 4 (break).
- R3: `lsr[7]` is 1 while at least one stored entry has a non-zero tag field, and 0 otherwise.
- R4: `trig_hit` is 1 when `count` is at or above the selected level: select 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R5: A data write while the queue is full is discarded and sets `lsr[1]`. A host line-status read clears `lsr[1]`. If both happen in one cycle, the set wins.
- R6: `lsr[0]` is 1 exactly when at least one byte is stored.
- R7: A configuration write with bits 0 and 1 both at 1 empties the queue and sets `flush_seen`. `flush_seen` stays at 1 until a host line-status read. No flag reports the bit-1 request itself, because it takes effect in the same edge.
- R8: A configuration write whose bit 0 differs from the current enable empties the queue. When bit 0 of a write is 0, bits 1 and 7..6 of that write are ignored.
- R9: A host pop while the queue is empty leaves `rd_data`, `lsr[4:2]` and `count` unchanged.
- R10: `full`, `empty` and the 5-bit `count` track the occupancy, from 0 to 16.
- R11: After reset the queue is empty, `lsr` is 0, `flush_seen` is 0 and the trigger select is 00.
- R12: A push and a pop in the same cycle on a partly filled queue leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_tag_we | input | 1 | Controller writes the staged error tags |
| ctl_tag_in | input | 3 | Tags {break, framing, parity} |
| ctl_data_we | input | 1 | Controller writes a received byte |
| ctl_data_in | input | 8 | Received byte |
| host_pop | input | 1 | Host reads one byte |
| host_lsr_rd | input | 1 | Host reads the line-status word |
| cfg_we | input | 1 | Host configuration write |
| cfg_in | input | 8 | Configuration: bit 0 enable, bit 1 flush, bits 7..6 trigger select |
| rd_data | output | 8 | Last popped byte |
| lsr | output | 8 | Line status: 0 ready, 1 overrun, 4..2 tags, 7 any stored error |
| trig_hit | output | 1 | Count has reached the trigger level |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entry |
| count | output | 5 | Stored entry count |
| flush_seen | output | 1 | A bit-1 flush happened since the last line-status read |

## Verification
Every result is registered, so each one is due one edge after its stimulus:

- A push updates `count`, `lsr[0]`, `lsr[7]` and `trig_hit` at that edge.
- A pop updates `rd_data` and `lsr[4:2]` at that edge.
- Overrun and `flush_seen` set or clear at that edge.

The bench drives inputs at the falling edge and holds them across one rising edge. It samples at the next falling edge, exactly one edge after each stimulus. The scoreboard queue holds each expected byte and its tags, and is compared at that same falling edge after every pop.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {Q_EMPTY, Q_PART, Q_FULL} occ_e;

    typedef struct packed {
        logic [2:0] tag;   // {break, framing, parity}
        logic [7:0] data;
    } entry_t;

    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  logic   flush,
    input  entry_t wr_entry,
    output entry_t head
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wptr, rptr;
    entry_t        mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wptr == AW'(i)) mem[i] <= wr_entry;
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_req,
    input  logic                       pop_req,
    input  logic                       flush,
    output logic                       push_ok,
    output logic                       pop_ok,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int CW = $clog2(DEPTH) + 1;

    occ_e state, state_nx;

    assign push_ok = push_req && (state != Q_FULL) && !flush;
    assign pop_ok  = pop_req && (state != Q_EMPTY) && !flush;

    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = Q_EMPTY;                                  // GO_FLUSH
        end else begin
            unique case (state)
                Q_EMPTY: if (push_ok) state_nx = Q_PART;         // GO_FILL
                Q_PART: begin
                    if (push_ok && !pop_ok && count == CW'(DEPTH - 1))
                        state_nx = Q_FULL;                       // GO_FULL
                    else if (pop_ok && !push_ok && count == CW'(1))
                        state_nx = Q_EMPTY;                      // GO_EMPTY
                end
                Q_FULL:  if (pop_ok) state_nx = Q_PART;          // GO_DRAIN
                default: state_nx = Q_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 count <= '0;
        else if (flush)             count <= '0;
        else if (push_ok && !pop_ok) count <= count + 1'b1;
        else if (pop_ok && !push_ok) count <= count - 1'b1;
    end

    always_comb begin
        full  = (state == Q_FULL);
        empty = (state == Q_EMPTY);
    end

    a_r10_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> count == CW'(DEPTH));
    a_r10_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (count == '0));
    a_r12_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_ok,
    input  logic       pop_ok,
    input  logic       overflow,
    input  logic       lsr_rd,
    input  logic       flush,
    input  logic [2:0] wr_tag,
    input  entry_t     head,
    output logic [7:0] rd_data,
    output logic [2:0] last_tag,
    output logic       overrun,
    output logic       err_any
);
    localparam int EW = $clog2(DEPTH) + 1;

    logic [EW-1:0] err_cnt;
    logic          inc, dec;

    assign inc = push_ok && (wr_tag != 3'b000);
    assign dec = pop_ok && (head.tag != 3'b000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          err_cnt <= '0;
        else if (flush)      err_cnt <= '0;
        else if (inc && !dec) err_cnt <= err_cnt + 1'b1;
        else if (dec && !inc) err_cnt <= err_cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            last_tag <= '0;
        end else if (pop_ok) begin
            rd_data  <= head.data;
            last_tag <= head.tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (overflow) overrun <= 1'b1;
        else if (lsr_rd)   overrun <= 1'b0;
    end

    assign err_any = (err_cnt != '0);

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overrun);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_ok |=> $stable(rd_data) && $stable(last_tag));
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_tag_we,
    input  logic [2:0] ctl_tag_in,
    input  logic       ctl_data_we,
    input  logic [7:0] ctl_data_in,
    input  logic       host_pop,
    input  logic       host_lsr_rd,
    input  logic       cfg_we,
    input  logic [7:0] cfg_in,
    output logic [7:0] rd_data,
    output logic [7:0] lsr,
    output logic       trig_hit,
    output logic       full,
    output logic       empty,
    output logic [4:0] count,
    output logic       flush_seen
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [2:0]    tag_stage;
    logic          en_q;
    logic [1:0]    trig_sel;
    logic          flush, push_ok, pop_ok, overrun, err_any;
    logic [2:0]    last_tag;
    logic [CW-1:0] cnt;
    logic [CW-1:0] level;
    entry_t        head, wr_entry;

    assign flush = cfg_we && ((cfg_in[0] != en_q) || (cfg_in[0] && cfg_in[1]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tag_stage <= '0;
        else if (ctl_tag_we)  tag_stage <= ctl_tag_in;
        else if (ctl_data_we) tag_stage <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            trig_sel <= 2'b00;
        end else if (cfg_we) begin
            en_q <= cfg_in[0];
            if (cfg_in[0]) trig_sel <= cfg_in[7:6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          flush_seen <= 1'b0;
        else if (cfg_we && cfg_in[0] && cfg_in[1]) flush_seen <= 1'b1;
        else if (host_lsr_rd)                flush_seen <= 1'b0;
    end

    assign wr_entry = '{tag: tag_stage, data: ctl_data_in};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(ctl_data_we), .pop_req(host_pop),
        .flush(flush), .push_ok(push_ok), .pop_ok(pop_ok), .count(cnt),
        .full(full), .empty(empty)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .flush(flush),
        .wr_entry(wr_entry), .head(head)
    );

    rxq_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
        .overflow(ctl_data_we && full && !flush), .lsr_rd(host_lsr_rd),
        .flush(flush), .wr_tag(tag_stage), .head(head), .rd_data(rd_data),
        .last_tag(last_tag), .overrun(overrun), .err_any(err_any)
    );

    always_comb begin
        unique case (trig_sel)
            2'd0:    level = CW'(trig_level(2'd0, DEPTH));
            2'd1:    level = CW'(trig_level(2'd1, DEPTH));
            2'd2:    level = CW'(trig_level(2'd2, DEPTH));
            default: level = CW'(trig_level(2'd3, DEPTH));
        endcase
    end

    assign trig_hit = (cnt >= level);
    assign count    = 5'(cnt);
    assign lsr      = {err_any, 2'b00, last_tag, overrun, !empty};

    a_r3_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[7] |-> !empty);
    a_r1_stage_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_data_we && !ctl_tag_we) |=> tag_stage == 3'b000);
    a_r8_ignored_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_in[0] && !en_q) |=> $stable(trig_sel) && $stable(cnt));
endmodule

// File: tb/tb_rxq_tagged_fifo.sv
module tb_rxq_tagged_fifo;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       ctl_tag_we = 0, ctl_data_we = 0, host_pop = 0, host_lsr_rd = 0, cfg_we = 0;
    logic [2:0] ctl_tag_in = 0;
    logic [7:0] ctl_data_in = 0, cfg_in = 0;
    logic [7:0] rd_data, lsr;
    logic       trig_hit, full, empty, flush_seen;
    logic [4:0] count;

    int checks = 0, fails = 0, model_cnt = 0;
    bit done = 0;
    logic [10:0] exp_q[$];

    always #10 clk = ~clk;

    rxq_tagged_fifo dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ctl_tag_we = 0; ctl_data_we = 0; host_pop = 0; host_lsr_rd = 0; cfg_we = 0;
    endtask

    task automatic push_byte(input logic [2:0] tg, input logic use_tag, input logic [7:0] d);
        if (use_tag) begin
            ctl_tag_we = 1; ctl_tag_in = tg; tick();
        end
        ctl_data_we = 1; ctl_data_in = d; tick();
        if (model_cnt < 16) begin
            exp_q.push_back({use_tag ? tg : 3'b000, d});
            model_cnt++;
        end
    endtask

    task automatic pop_check(input string req);
        logic [10:0] e;
        host_pop = 1; tick();
        e = exp_q.pop_front();
        model_cnt--;
        chk(req, rd_data, e[7:0]);
        chk(req, lsr[4:2], e[10:8]);
    endtask

    task automatic cfg(input logic [7:0] v);
        cfg_we = 1; cfg_in = v; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 count", count, 0);
        chk("R11 empty", empty, 1);
        chk("R11 lsr", lsr, 0);
        chk("R11 flush_seen", flush_seen, 0);
        chk("R11 trig", trig_hit, 0);

        cfg(8'h01);               // enable (bit0 change flushes an empty queue)
        chk("R7 no bit1 flag", flush_seen, 0);

        // R1/R3 tags travel with bytes; staging clears
        push_byte(3'b001, 1, 8'hA5);
        push_byte(3'b000, 0, 8'h3C);
        push_byte(3'b100, 1, 8'h7E);
        chk("R10 count3", count, 3);
        chk("R6 ready", lsr[0], 1);
        chk("R3 err any", lsr[7], 1);
        chk("R4 sel00 trig", trig_hit, 1);
        pop_check("R2 first");
        chk("R3 still err", lsr[7], 1);
        pop_check("R1 untagged byte");
        pop_check("R2 third");
        chk("R3 err cleared", lsr[7], 0);
        chk("R6 not ready", lsr[0], 0);
        chk("R10 empty", empty, 1);

        // R9 read while empty
        host_pop = 1; tick();
        chk("R9 data hold", rd_data, 8'h7E);
        chk("R9 tag hold", lsr[4:2], 3'b100);
        chk("R9 count", count, 0);

        // R4 trigger at 4, R8 bit0 change and ignored write
        cfg(8'h41);
        for (int i = 0; i < 3; i++) push_byte(0, 0, 8'(i));
        chk("R4 below 4", trig_hit, 0);
        push_byte(0, 0, 8'h03);
        chk("R4 at 4", trig_hit, 1);
        cfg(8'hC0); exp_q.delete(); model_cnt = 0;
        chk("R8 bit0 change flush", count, 0);
        cfg(8'hC2);
        chk("R8 ignored no flush flag", flush_seen, 0);
        for (int i = 0; i < 3; i++) push_byte(0, 0, 8'(i));
        chk("R8 sel kept below", trig_hit, 0);
        push_byte(0, 0, 8'h03);
        chk("R8 sel kept at 4", trig_hit, 1);
        cfg(8'h01); exp_q.delete(); model_cnt = 0;
        chk("R8 enable flush", count, 0);

        // R7 bit1 flush with bit0 set
        push_byte(0, 0, 8'h11);
        cfg(8'h03); exp_q.delete(); model_cnt = 0;
        chk("R7 flushed", count, 0);
        chk("R7 flag set", flush_seen, 1);
        host_lsr_rd = 1; tick();
        chk("R7 flag clear", flush_seen, 0);

        // R5 overrun and R4 level 14
        cfg(8'hC1);
        for (int i = 0; i < 13; i++) push_byte(0, 0, 8'(8'h20 + i));
        chk("R4 13 below 14", trig_hit, 0);
        push_byte(3'b010, 1, 8'h2D);
        chk("R4 at 14", trig_hit, 1);
        push_byte(0, 0, 8'h2E);
        push_byte(0, 0, 8'h2F);
        chk("R10 full", full, 1);
        chk("R10 count16", count, 16);
        chk("R5 no overrun yet", lsr[1], 0);
        push_byte(0, 0, 8'hEE);
        chk("R5 overrun", lsr[1], 1);
        chk("R5 count kept", count, 16);
        host_lsr_rd = 1; tick();
        chk("R5 overrun clear", lsr[1], 0);
        for (int i = 0; i < 16; i++) pop_check("R5 order after discard");
        chk("R10 drained", empty, 1);

        // R12 simultaneous push and pop
        push_byte(0, 0, 8'h55);
        push_byte(0, 0, 8'h66);
        ctl_data_we = 1; ctl_data_in = 8'h77; host_pop = 1; tick();
        chk("R12 count", count, 2);
        chk("R12 data", rd_data, 8'h55);
        void'(exp_q.pop_front());
        exp_q.push_back({3'b000, 8'h77});
        pop_check("R12 next");
        pop_check("R12 last");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule